// File: doc/BRIEF.md
# Soft-Start and Fault Hiccup Sequencer

This block governs how a multi-phase buck controller brings its PWM outputs into service and how it takes them out again when something goes wrong. It advances on a one-cycle `tick` strobe that marks each switching period, and it decides whether the phase outputs float (high impedance), are pulled low to clamp the lower switches, or run normally. It also produces a ramp value that the reference or duty path follows during start-up, a flag that marks the end of start-up, and a gate for the power-good signal.

Start-up proceeds in stages. The outputs float for a short settling interval, then clamp low for a longer one, and then run while the ramp climbs by one step per tick to full scale. Start-up is declared complete only when a fixed total tick count has elapsed, even if the ramp finished earlier. An over-voltage event locks the block into a crowbar state that only a supply-good drop can clear; in that state the outputs follow the over-voltage comparator and act as a hysteretic shunt. An overcurrent event while running floats the outputs, waits a long hiccup interval, and then restarts from the clamp stage. This repeats for as long as the fault comes back.

Top module: `softstart_seq`

## Requirements
- R1: While `supply_ok` is low, or `enable` is low with no over-voltage latched, `out_mode` is 0 (high impedance), `ramp` is 0 and `ss_done` is 0. After `supply_ok` goes low, this holds from the next cycle.
- R2: On the cycle after `supply_ok` and `enable` are both high, start-up begins. `out_mode` stays 0 until INIT_WAIT ticks have been counted.
- R3: After the INIT_WAIT ticks, `out_mode` is 1 (forced low) for CLAMP_CYC ticks, and `ramp` stays 0.
- R4: After the clamp stage, `out_mode` is 2 (run). `ramp` rises by exactly 1 on each tick, starting from 0, and saturates at RAMP_FULL.
- R5: `ss_done` rises only when TOTAL_CYC ticks have been counted from the start of start-up. While it is high, `ramp` equals RAMP_FULL. `pgood_gate` equals `ss_done` AND `supply_ok` AND `enable` AND NOT `ov_cmp` AND NOT `oc_flag`.
- R6: `ov_cmp` high while `supply_ok` is high latches over-voltage from the next cycle. While latched, `ss_done` and `ramp` are 0 and `enable` has no effect. Only `supply_ok` going low clears the latch.
- R7: While over-voltage is latched, `out_mode` is 1 in every cycle that `ov_cmp` is high and 0 in every cycle that it is low.
- R8: `oc_flag` high during the run stage or after start-up completes sets `out_mode` to 0 and `ramp` to 0 from the next cycle. The block then waits HICCUP_CYC ticks, re-enters the clamp stage, and proceeds as from R3. `ss_done` rises at the same count as in a normal start.
- R9: `oc_flag` is ignored during the high-impedance and clamp stages of start-up and during the hiccup wait.
- R10: If `oc_flag` recurs during the run stage of a restart, the hiccup wait of R8 repeats, without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Supply-good level; low acts as a power-on reset |
| enable | input | 1 | Converter enable level |
| ov_cmp | input | 1 | Over-voltage comparator state |
| oc_flag | input | 1 | Overcurrent flag |
| tick | input | 1 | One-cycle strobe per switching period |
| out_mode | output | 2 | 0 high impedance, 1 forced low, 2 run |
| ramp | output | $clog2(RAMP_FULL+1) | Soft-start ramp level |
| ss_done | output | 1 | Start-up complete |
| pgood_gate | output | 1 | Power-good enable |

## Verification
The hardest situation to reach is a second overcurrent that lands during a restart. To get there, the block must finish a full hiccup wait, pass again through the clamp stage (where the flag is ignored), and reach the run stage. The bench holds `oc_flag` high continuously while ticking every cycle, so each restart trips again as soon as it enters the run stage. A bench reference model marks these repeats so that any mismatch is reported against R10. The over-voltage crowbar is also driven directly: the comparator is toggled and `enable` is dropped while latched, to show that only a supply drop releases it.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [1:0] {
        DRV_HIZ = 2'd0,
        DRV_LOW = 2'd1,
        DRV_RUN = 2'd2
    } drv_mode_e;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_HIZ,
        PH_CLAMP,
        PH_RAMP,
        PH_DONE,
        PH_OVL,
        PH_HICCUP
    } phase_e;

    typedef struct packed {
        logic clr;
        logic step;
        logic fill;
    } ramp_ctl_t;

    function automatic drv_mode_e phase_to_mode(phase_e p, logic ov);
        drv_mode_e m;
        case (p)
            PH_CLAMP:         m = DRV_LOW;
            PH_RAMP, PH_DONE: m = DRV_RUN;
            PH_OVL:           m = ov ? DRV_LOW : DRV_HIZ;
            default:          m = DRV_HIZ;
        endcase
        return m;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ss_phase_fsm.sv
module ss_phase_fsm
    import sseq_pkg::*;
#(
    parameter int INIT_WAIT  = 32,
    parameter int CLAMP_CYC  = 150,
    parameter int TOTAL_CYC  = 2048,
    parameter int HICCUP_CYC = 2048
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      supply_ok,
    input  logic      enable,
    input  logic      ov_cmp,
    input  logic      oc_flag,
    input  logic      tick,
    output phase_e    phase,
    output ramp_ctl_t rctl
);

    localparam int MAXC = max2(TOTAL_CYC, HICCUP_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HIZ_END   = CW'(INIT_WAIT);
    localparam logic [CW-1:0] CLAMP_END = CW'(INIT_WAIT + CLAMP_CYC);
    localparam logic [CW-1:0] DONE_END  = CW'(TOTAL_CYC);
    localparam logic [CW-1:0] HIC_END   = CW'(HICCUP_CYC);

    logic [CW-1:0] cnt, nxt_cnt, cnt_inc;
    phase_e        nxt;

    assign cnt_inc = cnt + 1'b1;

    always_comb begin
        nxt     = phase;
        nxt_cnt = cnt;
        rctl    = '{clr: 1'b0, step: 1'b0, fill: 1'b0};
        if (!supply_ok) begin
            nxt     = PH_OFF;
            nxt_cnt = '0;
        end else if (phase == PH_OVL || ov_cmp) begin
            nxt     = PH_OVL;
            nxt_cnt = '0;
        end else if (!enable) begin
            nxt     = PH_OFF;
            nxt_cnt = '0;
        end else begin
            case (phase)
                PH_OFF: begin
                    nxt     = PH_HIZ;
                    nxt_cnt = '0;
                end
                PH_HIZ: if (tick) begin
                    nxt_cnt = cnt_inc;
                    if (cnt_inc == HIZ_END) nxt = PH_CLAMP;
                end
                PH_CLAMP: if (tick) begin
                    nxt_cnt = cnt_inc;
                    if (cnt_inc == CLAMP_END) nxt = PH_RAMP;
                end
                PH_RAMP: begin
                    if (oc_flag) begin
                        nxt     = PH_HICCUP;
                        nxt_cnt = '0;
                    end else if (tick) begin
                        nxt_cnt = cnt_inc;
                        if (cnt_inc == DONE_END) begin
                            nxt       = PH_DONE;
                            rctl.fill = 1'b1;
                        end else begin
                            rctl.step = 1'b1;
                        end
                    end
                end
                PH_DONE: if (oc_flag) begin
                    nxt     = PH_HICCUP;
                    nxt_cnt = '0;
                end
                PH_HICCUP: if (tick) begin
                    if (cnt_inc == HIC_END) begin
                        nxt     = PH_CLAMP;
                        nxt_cnt = HIZ_END;
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                default: begin
                    nxt     = PH_OFF;
                    nxt_cnt = '0;
                end
            endcase
        end
        rctl.clr = !(nxt == PH_RAMP || nxt == PH_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_OFF;
            cnt   <= '0;
        end else begin
            phase <= nxt;
            cnt   <= nxt_cnt;
        end
    end

    AST_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OVL && supply_ok) |=> phase == PH_OVL); // R6

    AST_OC_TRIP: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_RAMP || phase == PH_DONE) && oc_flag && supply_ok && enable && !ov_cmp)
        |=> phase == PH_HICCUP); // R8

    AST_OC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_HIZ || phase == PH_CLAMP || phase == PH_HICCUP) && supply_ok && enable && !ov_cmp)
        |=> phase != PH_HICCUP || $past(phase) == PH_HICCUP); // R9

endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen
    import sseq_pkg::*;
#(
    parameter int RAMP_FULL = 1023,
    localparam int RAMP_W   = $clog2(RAMP_FULL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_ctl_t         ctl,
    output logic [RAMP_W-1:0] level
);

    localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_FULL);

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)      level <= '0;
        else if (ctl.fill)       level <= TOP;
        else if (ctl.step && level != TOP) level <= level + 1'b1;
    end

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.clr && !ctl.fill && level != TOP)
        |=> level == $past(level) + 1'b1); // R4

    AST_RAMP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (level == TOP && !ctl.clr) |=> level == TOP); // R4

endmodule

// File: rtl/ss_drive_decode.sv
module ss_drive_decode
    import sseq_pkg::*;
(
    input  phase_e    phase,
    input  logic      ov_cmp,
    output drv_mode_e mode
);

    always_comb mode = phase_to_mode(phase, ov_cmp);

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import sseq_pkg::*;
#(
    parameter int INIT_WAIT  = 32,
    parameter int CLAMP_CYC  = 150,
    parameter int TOTAL_CYC  = 2048,
    parameter int HICCUP_CYC = 2048,
    parameter int RAMP_FULL  = 1023,
    localparam int RAMP_W    = $clog2(RAMP_FULL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              enable,
    input  logic              ov_cmp,
    input  logic              oc_flag,
    input  logic              tick,
    output logic [1:0]        out_mode,
    output logic [RAMP_W-1:0] ramp,
    output logic              ss_done,
    output logic              pgood_gate
);

    phase_e    phase;
    ramp_ctl_t rctl;
    drv_mode_e mode;

    ss_phase_fsm #(
        .INIT_WAIT (INIT_WAIT),
        .CLAMP_CYC (CLAMP_CYC),
        .TOTAL_CYC (TOTAL_CYC),
        .HICCUP_CYC(HICCUP_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .supply_ok(supply_ok),
        .enable   (enable),
        .ov_cmp   (ov_cmp),
        .oc_flag  (oc_flag),
        .tick     (tick),
        .phase    (phase),
        .rctl     (rctl)
    );

    ss_ramp_gen #(.RAMP_FULL(RAMP_FULL)) u_ramp (
        .clk  (clk),
        .rst  (rst),
        .ctl  (rctl),
        .level(ramp)
    );

    ss_drive_decode u_dec (
        .phase (phase),
        .ov_cmp(ov_cmp),
        .mode  (mode)
    );

    assign out_mode   = mode;
    assign ss_done    = (phase == PH_DONE);
    assign pgood_gate = ss_done && supply_ok && enable && !ov_cmp && !oc_flag;

    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (out_mode == 2'd0 && ramp == '0 && !ss_done)); // R1

    AST_CLAMP_RAMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_mode == 2'd1 |-> ramp == '0); // R3

    AST_DONE_FULL: assert property (@(posedge clk) disable iff (rst)
        ss_done |-> ramp == RAMP_W'(RAMP_FULL)); // R5

    AST_OV_KILLS_DONE: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && ov_cmp) |=> !ss_done && !pgood_gate); // R6

endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;

    localparam int IW = 4, CC = 6, TC = 64, HC = 40, RF = 31;
    localparam int S_OFF = 0, S_WAIT = 1, S_CLAMP = 2, S_RAMP = 3,
                   S_DONE = 4, S_OV = 5, S_OCW = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic supply_ok = 1'b0, enable = 1'b0, ov_cmp = 1'b0, oc_flag = 1'b0, tick = 1'b0;
    logic [1:0] out_mode;
    logic [4:0] ramp;
    logic ss_done, pgood_gate;

    int checks = 0, errors = 0;
    int m_st = S_OFF, m_cnt = 0, m_ramp = 0;
    bit m_aft = 1'b0, m_rep = 1'b0;

    softstart_seq #(.INIT_WAIT(IW), .CLAMP_CYC(CC), .TOTAL_CYC(TC),
                    .HICCUP_CYC(HC), .RAMP_FULL(RF)) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .enable(enable),
        .ov_cmp(ov_cmp), .oc_flag(oc_flag), .tick(tick),
        .out_mode(out_mode), .ramp(ramp), .ss_done(ss_done), .pgood_gate(pgood_gate)
    );

    always #2 clk = ~clk;

    // Reference model built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_st <= S_OFF; m_cnt <= 0; m_ramp <= 0; m_aft <= 0; m_rep <= 0;
        end else if (!supply_ok) begin
            m_st <= S_OFF; m_cnt <= 0; m_ramp <= 0; m_aft <= 0;
        end else if (m_st == S_OV || ov_cmp) begin
            m_st <= S_OV; m_cnt <= 0; m_ramp <= 0;
        end else if (!enable) begin
            m_st <= S_OFF; m_cnt <= 0; m_ramp <= 0; m_aft <= 0;
        end else begin
            case (m_st)
                S_OFF: begin m_st <= S_WAIT; m_cnt <= 0; end
                S_WAIT: if (tick) begin
                    m_cnt <= m_cnt + 1;
                    if (m_cnt + 1 == IW) m_st <= S_CLAMP;
                end
                S_CLAMP: if (tick) begin
                    m_cnt <= m_cnt + 1;
                    if (m_cnt + 1 == IW + CC) m_st <= S_RAMP;
                end
                S_RAMP: if (oc_flag) begin
                    m_st <= S_OCW; m_cnt <= 0; m_ramp <= 0; m_rep <= m_aft;
                end else if (tick) begin
                    m_cnt <= m_cnt + 1;
                    if (m_cnt + 1 == TC) begin
                        m_st <= S_DONE; m_ramp <= RF; m_aft <= 0;
                    end else if (m_ramp < RF) m_ramp <= m_ramp + 1;
                end
                S_DONE: if (oc_flag) begin
                    m_st <= S_OCW; m_cnt <= 0; m_ramp <= 0; m_rep <= m_aft;
                end
                S_OCW: if (tick) begin
                    if (m_cnt + 1 == HC) begin
                        m_st <= S_CLAMP; m_cnt <= IW; m_aft <= 1;
                    end else m_cnt <= m_cnt + 1;
                end
                default: m_st <= S_OFF;
            endcase
        end
    end

    function automatic int exp_mode(int st, bit ov);
        case (st)
            S_CLAMP: return 1;
            S_RAMP, S_DONE: return 2;
            S_OV: return ov ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int st, bit oc, bit rep, bit is_mode);
        case (st)
            S_OFF:   return "R1";
            S_WAIT:  return oc ? "R9" : "R2";
            S_CLAMP: return oc ? "R9" : "R3";
            S_RAMP:  return "R4";
            S_DONE:  return "R5";
            S_OV:    return is_mode ? "R7" : "R6";
            default: return rep ? "R10" : "R8";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int ep;
        ep = (m_st == S_DONE && supply_ok && enable && !ov_cmp && !oc_flag) ? 1 : 0;
        chk(tag_of(m_st, oc_flag, m_rep, 1'b1), int'(out_mode), exp_mode(m_st, ov_cmp));
        chk(tag_of(m_st, oc_flag, m_rep, 1'b0), int'(ramp), m_ramp);
        chk(m_st == S_OV ? "R6" : "R5", int'(ss_done), (m_st == S_DONE) ? 1 : 0);
        chk(m_st == S_OV ? "R6" : "R5", int'(pgood_gate), ep);
    endtask

    task automatic drive(bit s, bit e, bit ov, bit oc, bit t);
        @(negedge clk);
        compare_all();
        supply_ok = s; enable = e; ov_cmp = ov; oc_flag = oc; tick = t;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        bit s, e, ov, oc;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(out_mode), 0);
        chk("R1", int'(ramp), 0);
        chk("R1", int'(ss_done), 0);
        rst = 1'b0;

        // R9: overcurrent held through hi-Z and clamp stages of a clean start
        for (int i = 0; i < 120; i++)
            drive(1, 1, 0, (m_st == S_OFF || m_st == S_WAIT || m_st == S_CLAMP), 1);
        // R5: steady run after completion
        for (int i = 0; i < 10; i++) drive(1, 1, 0, 0, 1);

        // R6 R7: latch, toggle comparator, drop enable while latched
        drive(1, 1, 1, 0, 1);
        for (int i = 0; i < 30; i++) drive(1, (i < 10), (i % 4) < 2, 0, 1);
        drive(0, 1, 0, 0, 1);
        drive(0, 1, 0, 0, 1);

        // R8 R10: continuous overcurrent with every-cycle ticks
        for (int i = 0; i < 150; i++) drive(1, 1, 0, 0, 1);
        for (int i = 0; i < 400; i++) drive(1, 1, 0, 1, 1);
        for (int i = 0; i < 150; i++) drive(1, 1, 0, 0, 1);

        // Constrained random mix
        s = 1; e = 1; ov = 0; oc = 0;
        for (int i = 0; i < 20000; i++) begin
            if ($urandom % 600 == 0) s = 0; else if (!s && $urandom % 4 == 0) s = 1;
            if ($urandom % 300 == 0) e = !e;
            if (m_st == S_OV) ov = ($urandom % 3 == 0);
            else ov = ($urandom % 1500 == 0);
            oc = ($urandom % 120 == 0) || (oc && $urandom % 4 != 0);
            drive(s, e, ov, oc, ($urandom % 3) != 0);
        end

        @(negedge clk);
        compare_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule